// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the byte-wide programming and acknowledge front end of an eight-line interrupt controller. Software reaches it through two addresses. Address 0 takes the command that starts initialization, the mode commands and the operation commands. Address 1 takes the words of the initialization sequence and, once that sequence is over, the mask. The block holds the controller's settings: the mask, the vector base, the in-service bits, a 3-bit rotation offset and the mode flags. It runs the end-of-interrupt and rotation commands, and it answers register reads and poll reads.

The block does not rank pending requests itself. An external resolver gives it a winner flag and a winning line number, and the block publishes the mask, in-service bits, offset and mode flags that the resolver needs. On an acknowledge, from the acknowledge strobe or from a poll read, the block forms the vector and updates the in-service state. It also emits a one-cycle pulse with the line number, so that the request logic can clear an edge request.

Top module: `pic_cmd_if`

## Requirements
- R1: A write to address 0 with bit 4 set starts initialization. In that cycle it clears the mask, in-service bits, offset, base, read-select, poll, special mask, auto-EOI, rotate-on-auto-EOI and nested mode. It records bit 0 (a config word follows) and bit 1 (single unit), and the next address-1 write is the base word.
- R2: The base word stores bits 7:3 as the vector base. It moves to the cascade step if the unit is not single. If the unit is single, it moves to the config step when bit 0 was recorded and to normal otherwise. A write in the cascade step moves to the config step if bit 0 was recorded, and to normal otherwise. In normal state an address-1 write loads the mask.
- R3: A write in the config step loads nested mode from bit 4 and auto-EOI from bit 1, then returns to normal.
- R4: A write to address 0 with bit 4 clear and bit 3 set is a mode command. Bit 2 set arms poll. Bit 1 set loads read-select from bit 0. Bit 6 set loads the special mask flag from bit 5. With bit 6 clear, the special mask flag is unchanged.
- R5: Other address-0 writes decode bits 7:5 as an operation code. Codes 1 and 5 clear the in-service bit of highest priority. Priority runs from the line equal to the offset upward, modulo 8. Code 5 also sets the offset to that line + 1. With no bit in service, neither code changes anything.
- R6: Code 3 clears the in-service bit selected by bits 2:0. Code 7 clears that bit and also sets the offset to bits 2:0 + 1 (modulo 8).
- R7: Code 6 sets the offset to bits 2:0 + 1 (modulo 8). Codes 0 and 4 load rotate-on-auto-EOI from bit 7. Code 2 changes nothing.
- R8: While poll is not armed, the read data is the mask at address 1. At address 0 it is the in-service bits when read-select is 1, and the external request vector when read-select is 0.
- R9: While poll is armed, the read data is 0x80 OR the winning line when a winner exists, and 0x00 otherwise. A read strobe in that state acknowledges the winner and disarms poll.
- R10: The vector is the base in bits 7:3 and the line in bits 2:0, using line 7 when no winner exists. Acknowledging a winner sets its in-service bit when auto-EOI is off. When auto-EOI is on, it sets the offset to line + 1 if rotate-on-auto-EOI is set. It pulses ackFire with the line. With no winner, nothing changes.
- R11: In a cycle with a write strobe, acknowledge and read strobes have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (side effect only in poll) |
| addr | input | 1 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data |
| intAck | input | 1 | Interrupt acknowledge strobe |
| reqVec | input | 8 | Request vector from the request logic |
| winValid | input | 1 | Resolver reports a winning line |
| winLine | input | 3 | Winning line from the resolver |
| vector | output | 8 | Interrupt vector |
| ackFire | output | 1 | A winner was acknowledged this cycle |
| ackLine | output | 3 | Line acknowledged |
| maskOut | output | 8 | Mask register |
| isrOut | output | 8 | In-service bits |
| prioOffset | output | 3 | Rotation offset |
| specialMask | output | 1 | Special mask flag |
| nestedMode | output | 1 | Special fully nested flag |

## Verification
The assertions assume the resolver's winner flag and line are stable across the acknowledge edge. They also assume that software follows the initialization order, so the mask-load check applies only when the block reports its normal step. The bench changes the resolver inputs only at falling edges. It acknowledges only lines whose expected in-service effect it tracks, and it raises the write and acknowledge strobes together just once, deliberately, to test precedence.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  localparam int LINE_CNT = 8;
  localparam int LINE_W   = $clog2(LINE_CNT);
  localparam int DATA_W   = 8;
  localparam int BASE_W   = DATA_W - LINE_W;

  typedef enum logic [1:0] {
    STEP_NORMAL  = 2'd0,
    STEP_BASE    = 2'd1,
    STEP_CASCADE = 2'd2,
    STEP_CFG     = 2'd3
  } initStepT;

  typedef struct packed {
    logic startInit;
    logic loadBase;
    logic loadCfg;
    logic loadMask;
    logic armPoll;
    logic disarmPoll;
    logic loadReadSel;
    logic loadSpecMask;
    logic loadRotAeoi;
    logic clrNonSpec;
    logic rotAfterClear;
    logic clrSpecific;
    logic setOffset;
    logic ack;
  } cmdStrobeT;

  // highest-priority set bit, scanning upward from offs; MSB = found
  function automatic logic [LINE_W:0] findHighest(
      input logic [LINE_CNT-1:0] vec, input logic [LINE_W-1:0] offs);
    logic [LINE_W:0]   res;
    logic [LINE_W-1:0] idx;
    res = '0;
    for (int i = LINE_CNT - 1; i >= 0; i--) begin
      idx = offs + i[LINE_W-1:0];
      if (vec[idx]) res = {1'b1, idx};
    end
    return res;
  endfunction
endpackage

// File: rtl/pic_cmd_ctrl.sv
module pic_cmd_ctrl
  import pic_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              intAck,
  input  logic              pollArmed,
  output cmdStrobeT         strobe,
  output logic [1:0]        stepNow
);
  initStepT step;
  logic     needCfg;
  logic     singleUnit;

  assign stepNow = step;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step       <= STEP_NORMAL;
      needCfg    <= 1'b0;
      singleUnit <= 1'b0;
    end else if (wrEn && !addr && wrData[4]) begin
      step       <= STEP_BASE;
      needCfg    <= wrData[0];
      singleUnit <= wrData[1];
    end else if (wrEn && addr) begin
      case (step)
        STEP_BASE:    step <= singleUnit ? (needCfg ? STEP_CFG : STEP_NORMAL) : STEP_CASCADE;
        STEP_CASCADE: step <= needCfg ? STEP_CFG : STEP_NORMAL;
        STEP_CFG:     step <= STEP_NORMAL;
        default:      step <= STEP_NORMAL;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      if (!addr) begin
        if (wrData[4]) begin
          strobe.startInit = 1'b1;
        end else if (wrData[3]) begin
          strobe.armPoll      = wrData[2];
          strobe.loadReadSel  = wrData[1];
          strobe.loadSpecMask = wrData[6];
        end else begin
          case (wrData[7:5])
            3'd0, 3'd4: strobe.loadRotAeoi = 1'b1;
            3'd1:       strobe.clrNonSpec  = 1'b1;
            3'd5: begin
              strobe.clrNonSpec    = 1'b1;
              strobe.rotAfterClear = 1'b1;
            end
            3'd3:       strobe.clrSpecific = 1'b1;
            3'd6:       strobe.setOffset   = 1'b1;
            3'd7: begin
              strobe.clrSpecific = 1'b1;
              strobe.setOffset   = 1'b1;
            end
            default: ;
          endcase
        end
      end else begin
        case (step)
          STEP_NORMAL: strobe.loadMask = 1'b1;
          STEP_BASE:   strobe.loadBase = 1'b1;
          STEP_CFG:    strobe.loadCfg  = 1'b1;
          default: ;
        endcase
      end
    end else begin
      strobe.ack        = intAck || (rdEn && pollArmed);
      strobe.disarmPoll = rdEn && pollArmed;
    end
  end
endmodule

// File: rtl/pic_cmd_dp.sv
module pic_cmd_dp
  import pic_cmd_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  cmdStrobeT           strobe,
  input  logic                addr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [LINE_CNT-1:0] reqVec,
  input  logic                winValid,
  input  logic [LINE_W-1:0]   winLine,
  output logic [DATA_W-1:0]   rdData,
  output logic [DATA_W-1:0]   vector,
  output logic                ackFire,
  output logic [LINE_W-1:0]   ackLine,
  output logic [LINE_CNT-1:0] maskOut,
  output logic [LINE_CNT-1:0] isrOut,
  output logic [LINE_W-1:0]   prioOffset,
  output logic                specialMask,
  output logic                nestedMode,
  output logic                pollArmed,
  output logic                autoEoi
);
  logic [LINE_CNT-1:0] maskReg, isrReg;
  logic [LINE_W-1:0]   offset;
  logic [BASE_W-1:0]   baseReg;
  logic                readSel, specMask, rotAeoi, nested, aeoi, pollFlag;
  logic [LINE_W:0]     hiSvc;
  logic [LINE_W-1:0]   selLine;
  logic                ackTake;

  assign hiSvc   = findHighest(isrReg, offset);
  assign selLine = wrData[LINE_W-1:0];
  assign ackTake = strobe.ack && winValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0; isrReg <= '0; offset <= '0; baseReg <= '0;
      readSel <= 1'b0; specMask <= 1'b0; rotAeoi <= 1'b0;
      nested <= 1'b0; aeoi <= 1'b0; pollFlag <= 1'b0;
    end else if (strobe.startInit) begin
      maskReg <= '0; isrReg <= '0; offset <= '0; baseReg <= '0;
      readSel <= 1'b0; specMask <= 1'b0; rotAeoi <= 1'b0;
      nested <= 1'b0; aeoi <= 1'b0; pollFlag <= 1'b0;
    end else begin
      if (strobe.loadBase) baseReg <= wrData[DATA_W-1:LINE_W];
      if (strobe.loadCfg) begin
        nested <= wrData[4];
        aeoi   <= wrData[1];
      end
      if (strobe.loadMask) maskReg <= wrData;
      if (strobe.armPoll) pollFlag <= 1'b1;
      else if (strobe.disarmPoll) pollFlag <= 1'b0;
      if (strobe.loadReadSel) readSel <= wrData[0];
      if (strobe.loadSpecMask) specMask <= wrData[5];
      if (strobe.loadRotAeoi) rotAeoi <= wrData[7];
      if (strobe.clrNonSpec && hiSvc[LINE_W]) begin
        isrReg[hiSvc[LINE_W-1:0]] <= 1'b0;
        if (strobe.rotAfterClear) offset <= hiSvc[LINE_W-1:0] + 1'b1;
      end
      if (strobe.clrSpecific) isrReg[selLine] <= 1'b0;
      if (strobe.setOffset) offset <= selLine + 1'b1;
      if (ackTake) begin
        if (aeoi) begin
          if (rotAeoi) offset <= winLine + 1'b1;
        end else begin
          isrReg[winLine] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (pollFlag)
      rdData = winValid ? {1'b1, {(DATA_W-LINE_W-1){1'b0}}, winLine} : '0;
    else if (addr)
      rdData = maskReg;
    else
      rdData = readSel ? isrReg : reqVec;
  end

  assign vector      = {baseReg, winValid ? winLine : {LINE_W{1'b1}}};
  assign ackFire     = ackTake;
  assign ackLine     = winLine;
  assign maskOut     = maskReg;
  assign isrOut      = isrReg;
  assign prioOffset  = offset;
  assign specialMask = specMask;
  assign nestedMode  = nested;
  assign pollArmed   = pollFlag;
  assign autoEoi     = aeoi;
endmodule

// File: rtl/pic_cmd_if.sv
module pic_cmd_if
  import pic_cmd_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic                addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic                intAck,
  input  logic [LINE_CNT-1:0] reqVec,
  input  logic                winValid,
  input  logic [LINE_W-1:0]   winLine,
  output logic [DATA_W-1:0]   vector,
  output logic                ackFire,
  output logic [LINE_W-1:0]   ackLine,
  output logic [LINE_CNT-1:0] maskOut,
  output logic [LINE_CNT-1:0] isrOut,
  output logic [LINE_W-1:0]   prioOffset,
  output logic                specialMask,
  output logic                nestedMode
);
  cmdStrobeT  strobe;
  logic       pollArmed;
  logic       autoEoi;
  logic [1:0] stepNow;

  pic_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .intAck(intAck), .pollArmed(pollArmed),
    .strobe(strobe), .stepNow(stepNow)
  );

  pic_cmd_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .wrData(wrData),
    .reqVec(reqVec), .winValid(winValid), .winLine(winLine),
    .rdData(rdData), .vector(vector), .ackFire(ackFire), .ackLine(ackLine),
    .maskOut(maskOut), .isrOut(isrOut), .prioOffset(prioOffset),
    .specialMask(specialMask), .nestedMode(nestedMode),
    .pollArmed(pollArmed), .autoEoi(autoEoi)
  );
endmodule

// File: rtl/pic_cmd_chk.sv
module pic_cmd_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic       addr,
  input logic [7:0] wrData,
  input logic       intAck,
  input logic       winValid,
  input logic [7:0] vector,
  input logic       ackFire,
  input logic [2:0] ackLine,
  input logic [7:0] maskOut,
  input logic [7:0] isrOut,
  input logic [2:0] prioOffset,
  input logic [1:0] stepNow,
  input logic       pollArmed,
  input logic       autoEoi
);
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && wrData[4]) |=> (maskOut == 8'h00 && isrOut == 8'h00 && prioOffset == 3'd0)); // R1
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr && stepNow == 2'd0) |=> (maskOut == $past(wrData))); // R2
  AST_SPEC_EOI: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && wrData[7:3] == 5'b01100) |=> !isrOut[$past(wrData[2:0])]); // R6
  AST_ROT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && wrData[7:3] == 5'b11000) |=> (prioOffset == 3'($past(wrData[2:0]) + 3'd1))); // R7
  AST_POLL_DISARM: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && pollArmed) |=> !pollArmed); // R9
  AST_SPURIOUS_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !winValid) |-> (vector[2:0] == 3'd7 && !ackFire)); // R10
  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rstN)
    (ackFire && !autoEoi) |=> isrOut[$past(ackLine)]); // R10
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !ackFire); // R11
endmodule

bind pic_cmd_if pic_cmd_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .intAck(intAck), .winValid(winValid), .vector(vector),
  .ackFire(ackFire), .ackLine(ackLine), .maskOut(maskOut), .isrOut(isrOut),
  .prioOffset(prioOffset), .stepNow(stepNow), .pollArmed(pollArmed),
  .autoEoi(autoEoi)
);

// File: tb/pic_cmd_if_test.sv
module pic_cmd_if_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, addr = 1'b0, intAck = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] reqVec = 8'h5A;
  logic       winValid = 1'b0;
  logic [2:0] winLine = '0;
  logic [7:0] rdData, vector, maskOut, isrOut;
  logic       ackFire, specialMask, nestedMode;
  logic [2:0] ackLine, prioOffset;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pic_cmd_if uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .intAck(intAck), .reqVec(reqVec),
    .winValid(winValid), .winLine(winLine), .vector(vector),
    .ackFire(ackFire), .ackLine(ackLine), .maskOut(maskOut), .isrOut(isrOut),
    .prioOffset(prioOffset), .specialMask(specialMask), .nestedMode(nestedMode)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1; #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic ack(logic v, logic [2:0] l, output logic [7:0] vec, output logic fire);
    @(negedge clk); winValid = v; winLine = l; intAck = 1'b1;
    #1 vec = vector; fire = ackFire;
    @(negedge clk); intAck = 1'b0; winValid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset mask", maskOut, 8'h00);
    chk("R1 reset isr", isrOut, 8'h00);
    chk("R1 reset offset", {5'b0, prioOffset}, 8'h00);
  endtask

  task automatic t_init_full;
    wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h04); wr(1, 8'h10); wr(1, 8'hF0);
    chk("R3 nested loaded", {7'b0, nestedMode}, 8'h01);
    chk("R2 mask after four words", maskOut, 8'hF0);
  endtask

  task automatic t_ack;
    logic [7:0] v; logic f;
    ack(1, 3'd3, v, f);
    chk("R10 vector line3", v, 8'h43);
    chk("R10 ackFire", {7'b0, f}, 8'h01);
    chk("R10 isr set", isrOut, 8'h08);
    ack(1, 3'd5, v, f);
    ack(0, 3'd2, v, f);
    chk("R10 spurious vector", v, 8'h47);
    chk("R10 spurious no fire", {7'b0, f}, 8'h00);
    chk("R10 spurious isr", isrOut, 8'h28);
  endtask

  task automatic t_nonspec;
    logic [7:0] v; logic f;
    wr(0, 8'h20);
    chk("R5 eoi offset0", isrOut, 8'h20);
    ack(1, 3'd1, v, f);
    wr(0, 8'hC3);
    chk("R7 set offset", {5'b0, prioOffset}, 8'h04);
    wr(0, 8'h20);
    chk("R5 eoi rotated order", isrOut, 8'h02);
    ack(1, 3'd6, v, f);
    wr(0, 8'hA0);
    chk("R5 rotating eoi isr", isrOut, 8'h02);
    chk("R5 rotating eoi offset", {5'b0, prioOffset}, 8'h07);
  endtask

  task automatic t_spec;
    logic [7:0] v; logic f;
    ack(1, 3'd6, v, f);
    wr(0, 8'h66);
    chk("R6 specific eoi", isrOut, 8'h02);
    wr(0, 8'hE1);
    chk("R6 specific rotate isr", isrOut, 8'h00);
    chk("R6 specific rotate offset", {5'b0, prioOffset}, 8'h02);
    ack(1, 3'd4, v, f);
    wr(0, 8'h40);
    chk("R7 code2 isr", isrOut, 8'h10);
    chk("R7 code2 offset", {5'b0, prioOffset}, 8'h02);
  endtask

  task automatic t_reads;
    logic [7:0] d;
    wr(0, 8'h0B); rd(0, d);
    chk("R8 read isr", d, 8'h10);
    wr(0, 8'h0A); rd(0, d);
    chk("R8 read request", d, 8'h5A);
    rd(1, d);
    chk("R8 read mask", d, 8'hF0);
    wr(0, 8'h68);
    chk("R4 special mask set", {7'b0, specialMask}, 8'h01);
    wr(0, 8'h28);
    chk("R4 special mask kept", {7'b0, specialMask}, 8'h01);
    wr(0, 8'h48);
    chk("R4 special mask clear", {7'b0, specialMask}, 8'h00);
  endtask

  task automatic t_poll;
    logic [7:0] d;
    wr(0, 8'h0C);
    winValid = 1'b1; winLine = 3'd5;
    rd(0, d);
    winValid = 1'b0;
    chk("R9 poll data", d, 8'h85);
    chk("R9 poll ack isr", isrOut, 8'h30);
    rd(1, d);
    chk("R9 poll disarmed", d, 8'hF0);
    wr(0, 8'h0C);
    rd(0, d);
    chk("R9 poll empty", d, 8'h00);
    chk("R9 poll empty isr", isrOut, 8'h30);
    rd(1, d);
    chk("R4 poll disarmed after empty", d, 8'hF0);
  endtask

  task automatic t_precedence;
    @(negedge clk); addr = 1'b1; wrData = 8'h33; wrEn = 1'b1;
    intAck = 1'b1; winValid = 1'b1; winLine = 3'd0;
    @(negedge clk); wrEn = 1'b0; intAck = 1'b0; winValid = 1'b0;
    chk("R11 ack ignored", isrOut, 8'h30);
    chk("R11 write applied", maskOut, 8'h33);
  endtask

  task automatic t_init_short;
    logic [7:0] v; logic f;
    wr(0, 8'h12);
    chk("R1 init clears isr", isrOut, 8'h00);
    chk("R1 init clears mask", maskOut, 8'h00);
    chk("R1 init clears nested", {7'b0, nestedMode}, 8'h00);
    wr(1, 8'h20); wr(1, 8'h0F);
    chk("R2 single no cfg mask", maskOut, 8'h0F);
    ack(1, 3'd2, v, f);
    chk("R10 new base vector", v, 8'h22);
    wr(0, 8'h10); wr(1, 8'h00); wr(1, 8'h04); wr(1, 8'h3C);
    chk("R2 cascade no cfg mask", maskOut, 8'h3C);
  endtask

  task automatic t_aeoi;
    logic [7:0] v; logic f;
    wr(0, 8'h13); wr(1, 8'h60); wr(1, 8'h02);
    wr(1, 8'h81);
    chk("R3 normal after cfg", maskOut, 8'h81);
    wr(0, 8'h80);
    ack(1, 3'd4, v, f);
    chk("R10 aeoi vector", v, 8'h64);
    chk("R10 aeoi isr untouched", isrOut, 8'h00);
    chk("R10 aeoi rotate", {5'b0, prioOffset}, 8'h05);
    wr(0, 8'h00);
    ack(1, 3'd2, v, f);
    chk("R7 rotate off offset", {5'b0, prioOffset}, 8'h05);
    chk("R7 rotate off isr", isrOut, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_full();
    t_ack();
    t_nonspec();
    t_spec();
    t_reads();
    t_poll();
    t_precedence();
    t_init_short();
    t_aeoi();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule